// File: doc/BRIEF.md
# Operand Hazard Interlock and Bypass Steering

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) with eight architectural registers. Each cycle it compares the two source register numbers of the instruction in decode against the destination register of the older instructions now in execute and in memory. From the result it drives one stall request and two bypass selects, one for each ALU input multiplexer. The stall request freezes the fetch and decode pipeline registers and turns the instruction entering execute into a no-op. The selects travel with the decoded instruction and pick the ALU operand once it reaches execute.

A mode input picks one of two policies. In interlock-only mode every true dependence on execute or memory stalls decode until the producer has left memory. In bypass mode the value is taken from the execute/memory or memory/writeback pipeline register instead. A load in execute still costs one bubble, because its data exists only after the memory stage. The register file is taken to be write-through: a value written in writeback can be read by decode in the same cycle, so a producer in writeback never causes a hazard. It follows that two independent instructions between producer and consumer remove every stall.

Each source operand goes through a small classifier with four named states, re-evaluated every cycle. SRC_CLEAN means no producer matches. SRC_FROM_EX means a non-load in execute matches. SRC_LOAD_EX means a load in execute matches. SRC_FROM_MEM means only the producer in memory matches. The transitions are decided by priority: a match in execute (load → SRC_LOAD_EX, otherwise → SRC_FROM_EX) takes precedence over a match in memory (→ SRC_FROM_MEM). Everything else falls to SRC_CLEAN.

Top module: `hazard_interlock`

## Requirements
- R1: With `fwd_mode`=0, `stall` is 1 exactly when source A or source B equals the destination of a writing instruction in execute or in memory. Both operands are compared.
- R2: With `fwd_mode`=0, `byp_a` and `byp_b` are always 0, the register file code.
- R3: With `fwd_mode`=1, an operand matching a writing non-load in execute gets code 1 (execute/memory register), and that match does not stall.
- R4: With `fwd_mode`=1, an operand matching only the writing instruction in memory gets code 2 (memory/writeback register) with no stall, whether that instruction is a load or not.
- R5: When both execute and memory hold a matching writer, the execute one decides the outcome (youngest first).
- R6: With `fwd_mode`=1, an operand matching a writing load in execute raises `stall`. While `stall` is 1, both selects are 0.
- R7: A destination of register 0, or an instruction with its write flag low, never produces a stall or a nonzero select.
- R8: An operand with no matching writer gets code 0. If neither operand matches, `stall` is 0.
- R9: In a running pipeline, adjacent dependent instructions cost two bubbles in interlock-only mode, zero in bypass mode, and one in bypass mode when the producer is a load. After the load bubble the consumer reads code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_mode | input | 1 | 1 selects bypass mode, 0 interlock-only mode |
| id_src_a | input | 3 | First source register of the decoding instruction |
| id_src_b | input | 3 | Second source register of the decoding instruction |
| ex_dst | input | 3 | Destination register of the instruction in execute |
| ex_wr | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_dst | input | 3 | Destination register of the instruction in memory |
| mem_wr | input | 1 | Instruction in memory writes a register |
| stall | output | 1 | Hold fetch and decode, send a no-op into execute |
| byp_a | output | 2 | ALU input A source: 0 register file, 1 execute/memory, 2 memory/writeback |
| byp_b | output | 2 | ALU input B source, same coding as `byp_a` |

## Verification
The assertions take for granted that the inputs are settled two-state values. They also assume `ex_load` is only meaningful together with `ex_wr`, so a load that does not write is treated as a plain non-writer. The bench drives every combination of register numbers and flags, including loads with the write flag low, and checks each output after the inputs have settled. A small pipeline model then feeds the block the register numbers that a real program would present, cycle by cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int HZ_ARCH_REGS = 8;
    localparam int HZ_SPEC_W    = $clog2(HZ_ARCH_REGS);

    // ALU operand source codes
    typedef enum logic [1:0] {
        BYP_REGFILE = 2'd0,
        BYP_EXMEM   = 2'd1,
        BYP_MEMWB   = 2'd2
    } byp_sel_e;

    // Per-operand dependence class
    typedef enum logic [1:0] {
        SRC_CLEAN    = 2'd0,
        SRC_FROM_EX  = 2'd1,
        SRC_LOAD_EX  = 2'd2,
        SRC_FROM_MEM = 2'd3
    } src_state_e;

endpackage

// File: rtl/hz_dst_match.sv
module hz_dst_match #(
    parameter int SPEC_W = 3
) (
    input  logic [SPEC_W-1:0] src,
    input  logic [SPEC_W-1:0] dst,
    input  logic              wr,
    output logic              hit
);

    // Register 0 is never a real destination
    always_comb begin
        hit = wr && (dst != '0) && (dst == src);
    end

endmodule

// File: rtl/hz_operand_ctl.sv
module hz_operand_ctl
    import hz_pkg::*;
#(
    parameter int SPEC_W = 3
) (
    input  logic [SPEC_W-1:0] src,
    input  logic [SPEC_W-1:0] ex_dst,
    input  logic              ex_wr,
    input  logic              ex_load,
    input  logic [SPEC_W-1:0] mem_dst,
    input  logic              mem_wr,
    input  logic              fwd_mode,
    output logic              need_stall,
    output byp_sel_e          sel
);

    logic       hit_ex;
    logic       hit_mem;
    src_state_e cls;

    hz_dst_match #(.SPEC_W(SPEC_W)) u_match_ex (
        .src (src),
        .dst (ex_dst),
        .wr  (ex_wr),
        .hit (hit_ex)
    );

    hz_dst_match #(.SPEC_W(SPEC_W)) u_match_mem (
        .src (src),
        .dst (mem_dst),
        .wr  (mem_wr),
        .hit (hit_mem)
    );

    // Classification: youngest producer wins
    always_comb begin
        if (hit_ex && ex_load) begin
            cls = SRC_LOAD_EX;
        end else if (hit_ex) begin
            cls = SRC_FROM_EX;
        end else if (hit_mem) begin
            cls = SRC_FROM_MEM;
        end else begin
            cls = SRC_CLEAN;
        end
    end

    // Outputs per class
    always_comb begin
        need_stall = 1'b0;
        sel        = BYP_REGFILE;
        unique case (cls)
            SRC_CLEAN: begin
                need_stall = 1'b0;
                sel        = BYP_REGFILE;
            end
            SRC_FROM_EX: begin
                need_stall = !fwd_mode;
                sel        = fwd_mode ? BYP_EXMEM : BYP_REGFILE;
            end
            SRC_LOAD_EX: begin
                need_stall = 1'b1;
                sel        = BYP_REGFILE;
            end
            SRC_FROM_MEM: begin
                need_stall = !fwd_mode;
                sel        = fwd_mode ? BYP_MEMWB : BYP_REGFILE;
            end
            default: begin
                need_stall = 1'b0;
                sel        = BYP_REGFILE;
            end
        endcase
    end

    always_comb begin
        if (sel == BYP_EXMEM) begin
            // R3
            exmem_source_chk: assert (fwd_mode && ex_wr && !ex_load && ex_dst == src && src != '0);
        end
        if (sel == BYP_MEMWB) begin
            // R4
            memwb_source_chk: assert (mem_wr && mem_dst == src && mem_dst != '0 && !(ex_wr && ex_dst == src));
        end
    end

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
    import hz_pkg::*;
#(
    parameter  int NUM_REGS = HZ_ARCH_REGS,
    localparam int SPEC_W   = $clog2(NUM_REGS)
) (
    input  logic              fwd_mode,
    input  logic [SPEC_W-1:0] id_src_a,
    input  logic [SPEC_W-1:0] id_src_b,
    input  logic [SPEC_W-1:0] ex_dst,
    input  logic              ex_wr,
    input  logic              ex_load,
    input  logic [SPEC_W-1:0] mem_dst,
    input  logic              mem_wr,
    output logic              stall,
    output logic [1:0]        byp_a,
    output logic [1:0]        byp_b
);

    localparam int NUM_SRC = 2;

    logic [SPEC_W-1:0] src_vec  [NUM_SRC];
    logic              need_vec [NUM_SRC];
    byp_sel_e          sel_vec  [NUM_SRC];
    byp_sel_e          out_sel  [NUM_SRC];

    always_comb begin
        src_vec[0] = id_src_a;
        src_vec[1] = id_src_b;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
        hz_operand_ctl #(.SPEC_W(SPEC_W)) u_opnd (
            .src        (src_vec[g]),
            .ex_dst     (ex_dst),
            .ex_wr      (ex_wr),
            .ex_load    (ex_load),
            .mem_dst    (mem_dst),
            .mem_wr     (mem_wr),
            .fwd_mode   (fwd_mode),
            .need_stall (need_vec[g]),
            .sel        (sel_vec[g])
        );
    end

    always_comb begin
        stall = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            stall = stall | need_vec[i];
        end
    end

    // A bubble carries no operands
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            out_sel[i] = stall ? BYP_REGFILE : sel_vec[i];
        end
    end

    assign byp_a = out_sel[0];
    assign byp_b = out_sel[1];

    always_comb begin
        if (stall) begin
            // R1
            stall_has_writer_chk: assert (ex_wr || mem_wr);
        end
        if (fwd_mode && stall) begin
            // R6
            fwd_stall_load_chk: assert (ex_wr && ex_load && ex_dst != '0);
        end
        if (!fwd_mode) begin
            // R2
            lock_mode_rf_chk: assert (byp_a == 2'd0 && byp_b == 2'd0);
        end
        if (id_src_a == '0 && id_src_b == '0) begin
            // R7
            zero_src_chk: assert (!stall && byp_a == 2'd0 && byp_b == 2'd0);
        end
    end

endmodule

// File: tb/hazard_interlock_tb_top.sv
module hazard_interlock_tb_top;

    logic       clk = 1'b0;
    logic       fwd_mode = 1'b0;
    logic [2:0] id_src_a = '0;
    logic [2:0] id_src_b = '0;
    logic [2:0] ex_dst = '0;
    logic       ex_wr = 1'b0;
    logic       ex_load = 1'b0;
    logic [2:0] mem_dst = '0;
    logic       mem_wr = 1'b0;
    logic       stall;
    logic [1:0] byp_a;
    logic [1:0] byp_b;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    hazard_interlock dut_i (
        .fwd_mode (fwd_mode),
        .id_src_a (id_src_a),
        .id_src_b (id_src_b),
        .ex_dst   (ex_dst),
        .ex_wr    (ex_wr),
        .ex_load  (ex_load),
        .mem_dst  (mem_dst),
        .mem_wr   (mem_wr),
        .stall    (stall),
        .byp_a    (byp_a),
        .byp_b    (byp_b)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit hit(input int s, input int d, input bit w);
        return w && d != 0 && d == s;
    endfunction

    // Expected select for one operand, before the stall override
    function automatic int want_sel(input bit m, input int s, input int ed, input bit ew,
                                    input int md, input bit mw);
        if (!m) return 0;
        if (hit(s, ed, ew)) return 1;
        if (hit(s, md, mw)) return 2;
        return 0;
    endfunction

    task automatic apply(input bit m, input int a, input int b, input int ed, input bit ew,
                         input bit el, input int md, input bit mw);
        @(negedge clk);
        fwd_mode = m; id_src_a = 3'(a); id_src_b = 3'(b);
        ex_dst = 3'(ed); ex_wr = ew; ex_load = el; mem_dst = 3'(md); mem_wr = mw;
        #1;
    endtask

    // Pipeline model: producer, gap no-ops, consumer of r3
    task automatic run_pipe(input bit m, input bit ld, input int gap,
                            input int exp_stalls, input int exp_byp, input string tag);
        int n = gap + 2;
        int di = 0;
        int stalls = 0;
        int got_byp = -1;
        bit done = 0;
        int ed = 0; bit ew = 0; bit el = 0;
        int md = 0; bit mw = 0;
        for (int cyc = 0; cyc < 20 && !done; cyc++) begin
            int sa; int sb; int dd; bit dw; bit dl;
            if (di == 0) begin sa = 1; sb = 2; dd = 3; dw = 1; dl = ld; end
            else if (di == n - 1) begin sa = 3; sb = 6; dd = 5; dw = 1; dl = 0; end
            else begin sa = 0; sb = 0; dd = 0; dw = 0; dl = 0; end
            apply(m, sa, sb, ed, ew, el, md, mw);
            if (stall) stalls++;
            if (di == n - 1 && !stall) begin got_byp = byp_a; done = 1; end
            @(posedge clk);
            md = ed; mw = ew;
            if (stall) begin ed = 0; ew = 0; el = 0; end
            else begin ed = dd; ew = dw; el = dl; di++; end
        end
        chk(stalls == exp_stalls, {tag, " bubbles"}, stalls, exp_stalls);
        chk(got_byp == exp_byp, {tag, " consumer select"}, got_byp, exp_byp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        // Reset state: idle inputs
        apply(0, 0, 0, 0, 0, 0, 0, 0);
        chk(stall == 1'b0, "R8 idle stall", stall, 0);
        chk(byp_a == 2'd0 && byp_b == 2'd0, "R8 idle selects", byp_a, 0);

        // R1 operand B alone causes a stall in interlock mode
        apply(0, 1, 4, 4, 1, 0, 0, 0);
        chk(stall == 1'b1, "R1 src_b vs ex", stall, 1);
        // R3 non-load in execute is bypassed
        apply(1, 4, 1, 4, 1, 0, 0, 0);
        chk(stall == 1'b0 && byp_a == 2'd1, "R3 exmem select", byp_a, 1);
        // R4 load in memory is bypassed from memory/writeback
        apply(1, 2, 2, 0, 0, 0, 2, 1);
        chk(byp_a == 2'd2 && byp_b == 2'd2 && !stall, "R4 memwb select", byp_b, 2);
        // R5 execute beats memory
        apply(1, 6, 0, 6, 1, 0, 6, 1);
        chk(byp_a == 2'd1, "R5 youngest first", byp_a, 1);
        apply(1, 6, 0, 6, 1, 1, 6, 1);
        chk(stall == 1'b1 && byp_a == 2'd0, "R5 load in execute wins", stall, 1);
        // R6 load-use: both selects zero during the bubble
        apply(1, 5, 3, 5, 1, 1, 3, 1);
        chk(stall == 1'b1 && byp_b == 2'd0, "R6 load-use bubble", byp_b, 0);
        // R7 register 0 and non-writers
        apply(0, 0, 0, 0, 1, 0, 0, 1);
        chk(stall == 1'b0, "R7 r0 destination", stall, 0);
        apply(1, 7, 7, 7, 0, 1, 7, 0);
        chk(stall == 1'b0 && byp_a == 2'd0, "R7 write flag low", byp_a, 0);

        // Exhaustive sweep
        for (int code = 0; code < 65536; code++) begin
            int a = code & 7;
            int b = (code >> 3) & 7;
            int ed = (code >> 6) & 7;
            int md = (code >> 9) & 7;
            bit ew = code[12];
            bit el = code[13];
            bit mw = code[14];
            bit m = code[15];
            bit any_hit;
            bit ld_hit;
            int es;
            int ea;
            int eb;
            any_hit = hit(a, ed, ew) || hit(b, ed, ew) || hit(a, md, mw) || hit(b, md, mw);
            ld_hit = el && (hit(a, ed, ew) || hit(b, ed, ew));
            es = m ? int'(ld_hit) : int'(any_hit);
            ea = es ? 0 : want_sel(m, a, ed, ew, md, mw);
            eb = es ? 0 : want_sel(m, b, ed, ew, md, mw);
            apply(m, a, b, ed, ew, el, md, mw);
            chk(int'(stall) == es, !m ? "R1 sweep stall" : (ld_hit ? "R6 sweep stall" : "R3 sweep stall"),
                stall, es);
            chk(int'(byp_a) == ea, !m ? "R2 sweep byp_a" : (ea == 1 ? "R3 sweep byp_a" :
                (ea == 2 ? "R4 sweep byp_a" : "R8 sweep byp_a")), byp_a, ea);
            chk(int'(byp_b) == eb, !m ? "R2 sweep byp_b" : (eb == 1 ? "R3 sweep byp_b" :
                (eb == 2 ? "R4 sweep byp_b" : "R8 sweep byp_b")), byp_b, eb);
        end

        // R9 pipeline sequences
        run_pipe(0, 0, 0, 2, 0, "R9 interlock adjacent");
        run_pipe(0, 0, 1, 1, 0, "R9 interlock one gap");
        run_pipe(0, 0, 2, 0, 0, "R9 interlock two gaps");
        run_pipe(1, 0, 0, 0, 1, "R9 bypass adjacent");
        run_pipe(1, 1, 0, 1, 2, "R9 bypass load-use");
        run_pipe(1, 0, 1, 0, 2, "R9 bypass one gap");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule